// File: doc/BRIEF.md
# Card Host Controller Register Bank

This block is the memory-mapped register bank of a memory-card host controller. It sits between a simple 32-bit single-cycle bus and the controller's command and data engines. It holds the configuration registers that the engines read: power level, clock setting, command argument, command word, data timeout, transfer length and data control. It captures the response that the command engine returns. It collects sticky event flags into a status word that also carries live flags from the data engine. It turns a 16-word address window into push and pop strobes on a single data FIFO owned by the data engine, and it returns fixed identification bytes.

Software sets up a transfer through the bank and polls the status word or takes an interrupt. Each of the two interrupt lines has its own 32-bit mask and is high whenever a masked status bit is set. Sticky flags clear only when software writes ones to the clear register. Reads of the status word and of the FIFO-count register raise a one-cycle poll strobe, so the data engine can hold back new data until software has looked at the state.

Bus addresses are word indices, that is byte offset divided by four. Read data is combinational in the cycle of a read, and every register update happens at the clock edge that ends the access.

Top module: `sdmmc_regbank`

## Requirements
- R1: After reset every register, both masks and the sticky flags read zero, both interrupt lines are low and no strobe is active.
- R2: Power (byte 0x00), clock (0x04) and data control (0x2C) keep only bits [7:0] of a write. Data length (0x28) keeps bits [15:0]. Argument (0x08), data timer (0x24) and the masks (0x3C, 0x40) keep all 32 bits.
- R3: A write to the command register (0x0C) stores bits [10:0]. If bit 10 is set, `cmd_start` is high for exactly the cycle after the write, and bit 10 reads back as zero. Without bit 10 no start pulse occurs.
- R4: When `rsp_valid` is high at a clock edge, `rsp_index` and the four 32-bit words of `rsp_data` (word n in bits [32n+31:32n]) become readable at 0x10 (index in [5:0]) and at 0x14, 0x18, 0x1C and 0x20.
- R5: Status (0x34) reads the sticky flags in bits [10:0], the live `live_flags` input in bits [21:11] and zero above. A bit of `evt_set` sets its sticky flag, and the flag stays set after `evt_set` drops.
- R6: A write to the clear register (0x38) clears each sticky flag whose bit is one in bits [10:0] of the written value. Higher written bits have no effect. A flag set by `evt_set` in the same cycle stays set.
- R7: `irq0` is high exactly when status AND mask0 is nonzero, and `irq1` is high exactly when status AND mask1 is nonzero.
- R8: Any access to byte offsets 0x80 to 0xBC addresses the same FIFO. A read with `fifo_empty` low raises `fifo_rd_en` and returns `fifo_rdata`. A read with `fifo_empty` high returns zero and does not pop. A write raises `fifo_wr_en` with the written word on `fifo_wdata`.
- R9: A FIFO write while `dcnt_in` is zero is discarded: `fifo_wr_en` stays low.
- R10: 0x30 reads the remaining byte count `dcnt_in`. 0x48 reads the remaining word count, which is the byte count plus three, divided by four and rounded down.
- R11: Offsets 0xFE0 to 0xFFC read the bytes 0x81, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in that order, one byte per word in bits [7:0].
- R12: A read of status (0x34) or FIFO count (0x48) makes `poll_strobe` high for exactly the following cycle. Reads of other registers do not.
- R13: Reads of undefined offsets return zero. Writes to undefined or read-only offsets change no readable register.
- R14: A write to data control with bit 0 set makes `data_start` high for exactly the following cycle. With bit 0 clear no pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 10 | Word index (byte offset divided by four) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid during a read cycle, zero otherwise |
| pwr_level | output | 8 | Power register |
| clk_cfg | output | 8 | Clock register |
| cmd_arg | output | 32 | Command argument |
| cmd_word | output | 11 | Stored command word |
| cmd_start | output | 1 | One-cycle command start pulse |
| rsp_valid | input | 1 | Response capture strobe |
| rsp_index | input | 6 | Command index of the response |
| rsp_data | input | 128 | Four response words |
| evt_set | input | 11 | Sticky event set pulses |
| live_flags | input | 11 | Live data-engine flags |
| dtimer | output | 32 | Data timeout value |
| dlen | output | 16 | Transfer length in bytes |
| dctrl | output | 8 | Data control register |
| data_start | output | 1 | One-cycle data start pulse |
| dcnt_in | input | 16 | Remaining byte count from the data engine |
| fifo_empty | input | 1 | FIFO empty flag |
| fifo_rdata | input | 32 | FIFO head word |
| fifo_rd_en | output | 1 | FIFO pop strobe |
| fifo_wr_en | output | 1 | FIFO push strobe |
| fifo_wdata | output | 32 | FIFO push data |
| poll_strobe | output | 1 | One-cycle pulse after a status or FIFO-count read |
| irq0 | output | 1 | Interrupt line 0 |
| irq1 | output | 1 | Interrupt line 1 |

## Verification
The hardest case to reach from the ports is a clear write and an event for the same flag landing at the same clock edge. Here the set must win, and only the 11 low written bits may take part. The bench reaches it with a write task that drives `evt_set` in the very cycle of the clear access, then follows with a clear that sets every upper bit but touches a single low flag. The FIFO window is exercised at its first, last and a middle alias address, with the empty flag both low and high and with a zero and a nonzero byte count.

// File: rtl/sdmmc_regbank.sv
module sdmmc_regbank #(
  parameter int AW      = 10,
  parameter int CNT_W   = 16,
  parameter int STICK_W = 11,
  parameter int LIVE_W  = 11,
  parameter int IDX_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [7:0]        pwr_level,
  output logic [7:0]        clk_cfg,
  output logic [31:0]       cmd_arg,
  output logic [10:0]       cmd_word,
  output logic              cmd_start,
  input  logic              rsp_valid,
  input  logic [IDX_W-1:0]  rsp_index,
  input  logic [127:0]      rsp_data,
  input  logic [STICK_W-1:0] evt_set,
  input  logic [LIVE_W-1:0] live_flags,
  output logic [31:0]       dtimer,
  output logic [CNT_W-1:0]  dlen,
  output logic [7:0]        dctrl,
  output logic              data_start,
  input  logic [CNT_W-1:0]  dcnt_in,
  input  logic              fifo_empty,
  input  logic [31:0]       fifo_rdata,
  output logic              fifo_rd_en,
  output logic              fifo_wr_en,
  output logic [31:0]       fifo_wdata,
  output logic              poll_strobe,
  output logic              irq0,
  output logic              irq1
);
  localparam int ST_W = STICK_W + LIVE_W;
  localparam logic [AW-1:0] A_PWR  = AW'(8'h00 >> 2);
  localparam logic [AW-1:0] A_CLK  = AW'(8'h04 >> 2);
  localparam logic [AW-1:0] A_ARG  = AW'(8'h08 >> 2);
  localparam logic [AW-1:0] A_CMD  = AW'(8'h0C >> 2);
  localparam logic [AW-1:0] A_RIDX = AW'(8'h10 >> 2);
  localparam logic [AW-1:0] A_RSP0 = AW'(8'h14 >> 2);
  localparam logic [AW-1:0] A_RSP1 = AW'(8'h18 >> 2);
  localparam logic [AW-1:0] A_RSP2 = AW'(8'h1C >> 2);
  localparam logic [AW-1:0] A_RSP3 = AW'(8'h20 >> 2);
  localparam logic [AW-1:0] A_DTMR = AW'(8'h24 >> 2);
  localparam logic [AW-1:0] A_DLEN = AW'(8'h28 >> 2);
  localparam logic [AW-1:0] A_DCTL = AW'(8'h2C >> 2);
  localparam logic [AW-1:0] A_DCNT = AW'(8'h30 >> 2);
  localparam logic [AW-1:0] A_STAT = AW'(8'h34 >> 2);
  localparam logic [AW-1:0] A_CLR  = AW'(8'h38 >> 2);
  localparam logic [AW-1:0] A_MSK0 = AW'(8'h3C >> 2);
  localparam logic [AW-1:0] A_MSK1 = AW'(8'h40 >> 2);
  localparam logic [AW-1:0] A_FCNT = AW'(8'h48 >> 2);

  logic [STICK_W-1:0] sticky_q;
  logic [31:0]        mask0_q, mask1_q;
  logic [31:0]        rsp_q [4];
  logic [IDX_W-1:0]   ridx_q;
  logic [31:0]        status;
  logic [31:0]        id_byte;
  logic [CNT_W+1:0]   word_cnt;
  logic               wr, rd, fifo_win, id_win, clr_hit;

  assign wr       = bus_sel & bus_wr;
  assign rd       = bus_sel & ~bus_wr;
  assign fifo_win = bus_addr[AW-1:4] == (AW-4)'(2);
  assign id_win   = &bus_addr[AW-1:3];
  assign clr_hit  = wr && bus_addr == A_CLR;

  assign status   = 32'({live_flags, sticky_q});
  assign word_cnt = ((CNT_W+2)'(dcnt_in) + (CNT_W+2)'(3)) >> 2;

  assign fifo_wr_en = wr & fifo_win & (dcnt_in != '0);
  assign fifo_rd_en = rd & fifo_win & ~fifo_empty;
  assign fifo_wdata = bus_wdata;

  assign irq0 = |(status & mask0_q);
  assign irq1 = |(status & mask1_q);

  always_comb begin
    case (bus_addr[2:0])
      3'd0: id_byte = 32'h81;
      3'd1: id_byte = 32'h11;
      3'd2: id_byte = 32'h04;
      3'd3: id_byte = 32'h00;
      3'd4: id_byte = 32'h0D;
      3'd5: id_byte = 32'hF0;
      3'd6: id_byte = 32'h05;
      default: id_byte = 32'hB1;
    endcase
  end

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      if (id_win) bus_rdata = id_byte;
      else if (fifo_win) bus_rdata = fifo_empty ? '0 : fifo_rdata;
      else begin
        case (bus_addr)
          A_PWR:  bus_rdata = 32'(pwr_level);
          A_CLK:  bus_rdata = 32'(clk_cfg);
          A_ARG:  bus_rdata = cmd_arg;
          A_CMD:  bus_rdata = 32'(cmd_word);
          A_RIDX: bus_rdata = 32'(ridx_q);
          A_RSP0: bus_rdata = rsp_q[0];
          A_RSP1: bus_rdata = rsp_q[1];
          A_RSP2: bus_rdata = rsp_q[2];
          A_RSP3: bus_rdata = rsp_q[3];
          A_DTMR: bus_rdata = dtimer;
          A_DLEN: bus_rdata = 32'(dlen);
          A_DCTL: bus_rdata = 32'(dctrl);
          A_DCNT: bus_rdata = 32'(dcnt_in);
          A_STAT: bus_rdata = status;
          A_MSK0: bus_rdata = mask0_q;
          A_MSK1: bus_rdata = mask1_q;
          A_FCNT: bus_rdata = 32'(word_cnt);
          default: bus_rdata = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwr_level   <= '0;
      clk_cfg     <= '0;
      cmd_arg     <= '0;
      cmd_word    <= '0;
      dtimer      <= '0;
      dlen        <= '0;
      dctrl       <= '0;
      mask0_q     <= '0;
      mask1_q     <= '0;
      cmd_start   <= 1'b0;
      data_start  <= 1'b0;
      poll_strobe <= 1'b0;
    end else begin
      cmd_start   <= wr && bus_addr == A_CMD && bus_wdata[10];
      data_start  <= wr && bus_addr == A_DCTL && bus_wdata[0];
      poll_strobe <= rd && (bus_addr == A_STAT || bus_addr == A_FCNT);
      if (wr) begin
        case (bus_addr)
          A_PWR:  pwr_level <= bus_wdata[7:0];
          A_CLK:  clk_cfg   <= bus_wdata[7:0];
          A_ARG:  cmd_arg   <= bus_wdata;
          A_CMD:  cmd_word  <= {1'b0, bus_wdata[9:0]};
          A_DTMR: dtimer    <= bus_wdata;
          A_DLEN: dlen      <= bus_wdata[CNT_W-1:0];
          A_DCTL: dctrl     <= bus_wdata[7:0];
          A_MSK0: mask0_q   <= bus_wdata;
          A_MSK1: mask1_q   <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sticky_q <= '0;
    else sticky_q <= (sticky_q & ~(clr_hit ? bus_wdata[STICK_W-1:0] : '0)) | evt_set;
  end

  genvar g;
  generate
    for (g = 0; g < 4; g++) begin : g_rsp
      always_ff @(posedge clk) begin
        if (!rst_n) rsp_q[g] <= '0;
        else if (rsp_valid) rsp_q[g] <= rsp_data[32*g +: 32];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) ridx_q <= '0;
    else if (rsp_valid) ridx_q <= rsp_index;
  end
endmodule

// File: rtl/sdmmc_regbank_chk.sv
module sdmmc_regbank_chk #(
  parameter int AW    = 10,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic [AW-1:0]    bus_addr,
  input logic [31:0]      bus_wdata,
  input logic [31:0]      bus_rdata,
  input logic             cmd_start,
  input logic             data_start,
  input logic             poll_strobe,
  input logic [CNT_W-1:0] dcnt_in,
  input logic             fifo_empty,
  input logic             fifo_rd_en,
  input logic             fifo_wr_en
);
  // R3
  cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |-> $past(bus_sel && bus_wr && bus_addr == AW'(3) && bus_wdata[10]));

  // R14
  data_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_start |-> $past(bus_sel && bus_wr && bus_addr == AW'(11) && bus_wdata[0]));

  // R12
  poll_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    poll_strobe |-> $past(bus_sel && !bus_wr && (bus_addr == AW'(13) || bus_addr == AW'(18))));

  // R9
  push_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr_en |-> (dcnt_in != '0 && bus_sel && bus_wr));

  // R8
  pop_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd_en |-> (!fifo_empty && bus_sel && !bus_wr));

  // R8
  one_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fifo_rd_en, fifo_wr_en}));

  // R13
  idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |-> bus_rdata == '0);
endmodule

bind sdmmc_regbank sdmmc_regbank_chk #(.AW(AW), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .cmd_start(cmd_start), .data_start(data_start), .poll_strobe(poll_strobe),
  .dcnt_in(dcnt_in), .fifo_empty(fifo_empty), .fifo_rd_en(fifo_rd_en),
  .fifo_wr_en(fifo_wr_en)
);

// File: tb/sdmmc_regbank_test.sv
`timescale 1ns/1ps
module sdmmc_regbank_test;
  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [9:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [7:0] pwr_level, clk_cfg, dctrl;
  logic [31:0] cmd_arg, dtimer, fifo_wdata;
  logic [10:0] cmd_word;
  logic cmd_start, data_start, fifo_rd_en, fifo_wr_en, poll_strobe, irq0, irq1;
  logic rsp_valid = 0;
  logic [5:0] rsp_index = '0;
  logic [127:0] rsp_data = '0;
  logic [10:0] evt_set = '0, live_flags = '0;
  logic [15:0] dlen, dcnt_in = '0;
  logic fifo_empty = 1;
  logic [31:0] fifo_rdata = '0;

  int n_vec = 0, n_err = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  logic last_rd_en, last_wr_en;
  logic [31:0] last_wdata;

  always #2 clk = ~clk;

  sdmmc_regbank uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwr_level(pwr_level), .clk_cfg(clk_cfg), .cmd_arg(cmd_arg),
    .cmd_word(cmd_word), .cmd_start(cmd_start), .rsp_valid(rsp_valid),
    .rsp_index(rsp_index), .rsp_data(rsp_data), .evt_set(evt_set),
    .live_flags(live_flags), .dtimer(dtimer), .dlen(dlen), .dctrl(dctrl),
    .data_start(data_start), .dcnt_in(dcnt_in), .fifo_empty(fifo_empty),
    .fifo_rdata(fifo_rdata), .fifo_rd_en(fifo_rd_en), .fifo_wr_en(fifo_wr_en),
    .fifo_wdata(fifo_wdata), .poll_strobe(poll_strobe), .irq0(irq0), .irq1(irq1)
  );

  always @(negedge clk) begin
    if (bus_sel && !bus_wr && exp_q.size() != 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_vec++;
      if (bus_rdata !== e) begin
        n_err++;
        $display("FAIL %s addr=%03h actual=%08h expected=%08h", t, bus_addr, bus_rdata, e);
      end
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string t);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%08h expected=%08h", t, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [9:0] a, input logic [31:0] d,
                        input logic [10:0] ev);
    @(posedge clk); #1;
    bus_sel = 1; bus_wr = w; bus_addr = a; bus_wdata = d; evt_set = ev;
    @(negedge clk);
    last_rd_en = fifo_rd_en; last_wr_en = fifo_wr_en; last_wdata = fifo_wdata;
    @(posedge clk); #1;
    bus_sel = 0; bus_wr = 0; evt_set = '0;
  endtask

  task automatic rd(input logic [9:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    access(1'b0, a, '0, '0);
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    access(1'b1, a, d, '0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    logic [7:0] ids [8] = '{8'h81, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    rd(10'h00, 0, "R1 power");
    rd(10'h01, 0, "R1 clock");
    rd(10'h03, 0, "R1 command");
    rd(10'h0D, 0, "R1 status");
    rd(10'h0F, 0, "R1 mask0");
    rd(10'h05, 0, "R1 resp0");
    chk({irq1, irq0, cmd_start, data_start}, 0, "R1 irq and pulses");

    // R2 field widths
    wr(10'h00, 32'hABCD_1234); rd(10'h00, 32'h34, "R2 power width");
    wr(10'h01, 32'hFFFF_FF5A); rd(10'h01, 32'h5A, "R2 clock width");
    wr(10'h0A, 32'h1234_5678); rd(10'h0A, 32'h5678, "R2 length width");
    wr(10'h02, 32'hDEAD_BEEF); rd(10'h02, 32'hDEAD_BEEF, "R2 argument");
    wr(10'h09, 32'h0BAD_F00D); rd(10'h09, 32'h0BAD_F00D, "R2 timer");

    // R14 data start
    wr(10'h0B, 32'h0000_01F2);
    chk(data_start, 0, "R14 no start without bit0");
    rd(10'h0B, 32'hF2, "R2 control width");
    wr(10'h0B, 32'h0000_0003);
    chk(data_start, 1, "R14 start pulse");
    @(posedge clk); #1;
    chk(data_start, 0, "R14 pulse one cycle");

    // R3 command
    wr(10'h03, 32'hFFFF_F455);
    chk(cmd_start, 1, "R3 start pulse");
    rd(10'h03, 32'h055, "R3 enable self clears");
    chk(cmd_start, 0, "R3 pulse one cycle");
    wr(10'h03, 32'h0000_0042);
    chk(cmd_start, 0, "R3 no start without enable");

    // R4 response capture
    @(posedge clk); #1;
    rsp_valid = 1; rsp_index = 6'h2A;
    rsp_data = {32'h4444_4444, 32'h3333_3333, 32'h2222_2222, 32'h1111_1111};
    @(posedge clk); #1;
    rsp_valid = 0; rsp_data = '0;
    rd(10'h04, 32'h2A, "R4 index");
    rd(10'h05, 32'h1111_1111, "R4 word0");
    rd(10'h06, 32'h2222_2222, "R4 word1");
    rd(10'h07, 32'h3333_3333, "R4 word2");
    rd(10'h08, 32'h4444_4444, "R4 word3");

    // R5 sticky and live status
    @(posedge clk); #1; evt_set = 11'h041;
    @(posedge clk); #1; evt_set = 0;
    rd(10'h0D, 32'h41, "R5 sticky held");
    live_flags = 11'h7FF;
    rd(10'h0D, 32'h003F_F841, "R5 live flags");
    live_flags = 0;

    // R7 interrupts
    wr(10'h0F, 32'h0000_0040);
    chk({irq1, irq0}, 2'b01, "R7 irq0 from mask0");
    wr(10'h10, 32'h0000_0800);
    chk(irq1, 0, "R7 irq1 masked bit clear");
    live_flags = 11'h001; #1;
    chk(irq1, 1, "R7 irq1 live bit");
    live_flags = 0; #1;
    chk(irq1, 0, "R7 irq1 drops");

    // R6 clear
    wr(10'h0E, 32'hFFFF_F801);
    rd(10'h0D, 32'h40, "R6 clear low bits only");
    chk(irq0, 1, "R7 irq0 still set");
    wr(10'h0E, 32'h0000_0040);
    rd(10'h0D, 32'h0, "R6 clear all");
    chk(irq0, 0, "R7 irq0 after clear");
    access(1'b1, 10'h0E, 32'h0000_0004, 11'h004);
    rd(10'h0D, 32'h4, "R6 set wins over clear");
    wr(10'h0E, 32'h0000_0004);

    // R8 FIFO window
    fifo_empty = 0; fifo_rdata = 32'hCAFE_0001;
    rd(10'h20, 32'hCAFE_0001, "R8 first alias read");
    chk(last_rd_en, 1, "R8 pop first alias");
    rd(10'h2F, 32'hCAFE_0001, "R8 last alias read");
    chk(last_rd_en, 1, "R8 pop last alias");
    fifo_empty = 1;
    rd(10'h27, 0, "R8 empty read zero");
    chk(last_rd_en, 0, "R8 no pop when empty");
    dcnt_in = 16'd8;
    wr(10'h25, 32'h1122_3344);
    chk({31'b0, last_wr_en}, 1, "R8 push");
    chk(last_wdata, 32'h1122_3344, "R8 push data");

    // R9 discarded write
    dcnt_in = 0;
    wr(10'h20, 32'h5555_AAAA);
    chk(last_wr_en, 0, "R9 write discarded");

    // R10 counts, R12 poll strobe
    dcnt_in = 16'd13;
    rd(10'h0C, 32'd13, "R10 byte count");
    chk(poll_strobe, 0, "R12 no strobe on other read");
    rd(10'h12, 32'd4, "R10 word count");
    chk(poll_strobe, 1, "R12 strobe on count read");
    dcnt_in = 16'hFFFF;
    rd(10'h12, 32'h4000, "R10 word count max");
    rd(10'h0D, 32'h0, "R12 status read");
    chk(poll_strobe, 1, "R12 strobe on status read");
    @(posedge clk); #1;
    chk(poll_strobe, 0, "R12 strobe one cycle");

    // R11 ID bytes
    for (int i = 0; i < 8; i++) rd(10'h3F8 + 10'(i), 32'(ids[i]), "R11 id byte");

    // R13 undefined and read-only
    wr(10'h11, 32'hFFFF_FFFF);
    rd(10'h11, 0, "R13 undefined read");
    rd(10'h10, 32'h0000_0800, "R13 mask1 untouched");
    wr(10'h0C, 32'h0000_0001);
    rd(10'h0C, 32'hFFFF, "R13 count read-only");
    wr(10'h40, 32'h1234_5678);
    rd(10'h40, 0, "R13 outside map");
    rd(10'h13, 0, "R13 gap read");

    repeat (2) @(posedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule